// File: doc/BRIEF.md
# Reconfigurable Timer Compare Unit

This block watches a running timer count and raises compare flags when the count reaches programmed values. Two 8-bit compare registers, A and B, are held inside the block and loaded through byte-wide write strobes. In narrow mode each register is compared on its own against the low byte of the count, and each drives its own flag. In wide mode the two registers join into one 16-bit compare value, with B as the high byte and A as the low byte, and a single comparator checks it against the full count. Only flag A can be raised in this mode.

Equality is evaluated on every clock, but a flag is raised only on a timer tick (the counter's clock enable) during which the match holds. The flag appears one clock after that tick. A match that lasts over several ticks raises the flag only once, on the first of them. Each flag, gated by its enable, drives an interrupt request line. A flag is dropped by an interrupt acknowledge or by a software write-one-to-clear strobe. When a set and a clear fall in the same clock, the set takes precedence.

Top module: `dual_compare_unit`

## Requirements
- R1: After reset both flags, both interrupt lines and both compare registers read zero.
- R2: In narrow mode (wideMode=0), if count[7:0] equals register A during a clock with tick=1, flagA is 1 from the next clock. If the two values differ, that tick leaves flagA unchanged.
- R3: In narrow mode, register B is compared against count[7:0] and drives flagB independently of register A and flagA.
- R4: In wide mode (wideMode=1), the value {regB, regA}, with B in bits 15:8, is compared against count[15:0] and a match sets flagA. flagB never sets while wideMode=1.
- R5: In wide mode a match on the low byte alone, with a different high byte, sets no flag.
- R6: A match that stays true over consecutive ticks sets its flag only on the first of them. The flag can set again only after a tick without a match.
- R7: irqA equals flagA AND ieA, and irqB equals flagB AND ieB.
- R8: ackA or swClrA held high for one clock clears flagA on the next clock. ackB and swClrB do the same for flagB.
- R9: If a set condition and a clear strobe for the same flag occur in the same clock, the flag is 1 afterwards.
- R10: A match with tick=0 sets no flag, however long it lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer clock enable, one clock wide |
| count | input | 16 | Current timer count |
| wideMode | input | 1 | 1 selects the single 16-bit comparator |
| wrEnA | input | 1 | Loads wrData into register A |
| wrEnB | input | 1 | Loads wrData into register B |
| wrData | input | 8 | Write data for the compare registers |
| ieA | input | 1 | Interrupt enable for flag A |
| ieB | input | 1 | Interrupt enable for flag B |
| ackA | input | 1 | Interrupt acknowledge, clears flag A |
| ackB | input | 1 | Interrupt acknowledge, clears flag B |
| swClrA | input | 1 | Software write-one-to-clear for flag A |
| swClrB | input | 1 | Software write-one-to-clear for flag B |
| flagA | output | 1 | Compare flag A |
| flagB | output | 1 | Compare flag B |
| irqA | output | 1 | Interrupt request A |
| irqB | output | 1 | Interrupt request B |

## Verification
The bench uses equal A and B values in wide mode, where a narrow-mode match would wrongly raise flagB. It also applies a low-byte-only match in wide mode, which a design ignoring the high byte would flag. It holds a match with the tick low to catch a flag that is set without a tick, and repeats a tick on an unchanged count to catch a flag that re-arms on every tick. It drives a clear strobe into the clock of a set to expose reversed priority, which would leave the flag low.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  // One-clock strobes from the datapath to the flag control
  typedef struct packed {
    logic setB;
    logic setA;
  } hitStrb_t;
endpackage

// File: rtl/cmp_datapath.sv
module cmp_datapath
  import cmp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic [CNT_W-1:0] count,
  input  logic             wideMode,
  input  logic             wrEnA,
  input  logic             wrEnB,
  input  logic [CNT_W/2-1:0] wrData,
  output hitStrb_t         strb
);
  localparam int HALF_W = CNT_W / 2;

  logic [HALF_W-1:0] regA, regB;
  logic              matchA, matchB;
  logic [1:0]        prevMatch;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regA <= '0;
      regB <= '0;
    end else begin
      if (wrEnA) regA <= wrData;
      if (wrEnB) regB <= wrData;
    end
  end

  // Comparator selection: two narrow comparators or one wide comparator
  always_comb begin
    if (wideMode) begin
      matchA = ({regB, regA} == count);
      matchB = 1'b0;
    end else begin
      matchA = (regA == count[HALF_W-1:0]);
      matchB = (regB == count[HALF_W-1:0]);
    end
  end

  // Match state as seen at the last tick, for one-shot setting
  always_ff @(posedge clk) begin
    if (!rstN) prevMatch <= '0;
    else if (tick) prevMatch <= {matchB, matchA};
  end

  always_comb begin
    strb.setA = tick && matchA && !prevMatch[0];
    strb.setB = tick && matchB && !prevMatch[1];
  end

  AST_ONE_SHOT_A: assert property (@(posedge clk) disable iff (!rstN)
    strb.setA |=> !strb.setA); // R6
  AST_ONE_SHOT_B: assert property (@(posedge clk) disable iff (!rstN)
    strb.setB |=> !strb.setB); // R6
endmodule

// File: rtl/cmp_control.sv
module cmp_control
  import cmp_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  hitStrb_t          strb,
  input  logic [NUM_CH-1:0] ie,
  input  logic [NUM_CH-1:0] ack,
  input  logic [NUM_CH-1:0] swClr,
  output logic [NUM_CH-1:0] flag,
  output logic [NUM_CH-1:0] irq
);
  logic [NUM_CH-1:0] setVec;
  logic [NUM_CH-1:0] clrVec;

  assign setVec = {strb.setB, strb.setA};
  assign clrVec = ack | swClr;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    always_ff @(posedge clk) begin
      if (!rstN)           flag[ch] <= 1'b0;
      else if (setVec[ch]) flag[ch] <= 1'b1;
      else if (clrVec[ch]) flag[ch] <= 1'b0;
    end
    assign irq[ch] = flag[ch] & ie[ch];
  end

  AST_SET_WINS_A: assert property (@(posedge clk) disable iff (!rstN)
    strb.setA |=> flag[0]); // R9
  AST_SET_WINS_B: assert property (@(posedge clk) disable iff (!rstN)
    strb.setB |=> flag[1]); // R9
  AST_CLEAR_A: assert property (@(posedge clk) disable iff (!rstN)
    (clrVec[0] && !strb.setA) |=> !flag[0]); // R8
  AST_CLEAR_B: assert property (@(posedge clk) disable iff (!rstN)
    (clrVec[1] && !strb.setB) |=> !flag[1]); // R8
endmodule

// File: rtl/dual_compare_unit.sv
module dual_compare_unit
  import cmp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic [CNT_W-1:0] count,
  input  logic             wideMode,
  input  logic             wrEnA,
  input  logic             wrEnB,
  input  logic [CNT_W/2-1:0] wrData,
  input  logic             ieA,
  input  logic             ieB,
  input  logic             ackA,
  input  logic             ackB,
  input  logic             swClrA,
  input  logic             swClrB,
  output logic             flagA,
  output logic             flagB,
  output logic             irqA,
  output logic             irqB
);
  hitStrb_t   strb;
  logic [1:0] flagVec, irqVec;

  cmp_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .tick(tick), .count(count),
    .wideMode(wideMode), .wrEnA(wrEnA), .wrEnB(wrEnB),
    .wrData(wrData), .strb(strb)
  );

  cmp_control #(.NUM_CH(2)) u_ctl (
    .clk(clk), .rstN(rstN), .strb(strb),
    .ie({ieB, ieA}), .ack({ackB, ackA}), .swClr({swClrB, swClrA}),
    .flag(flagVec), .irq(irqVec)
  );

  assign flagA = flagVec[0];
  assign flagB = flagVec[1];
  assign irqA  = irqVec[0];
  assign irqB  = irqVec[1];

  AST_WIDE_NO_B: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagB) |-> $past(tick && !wideMode)); // R4
  AST_TICK_NEEDED_A: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagA) |-> $past(tick)); // R10
  AST_TICK_NEEDED_B: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagB) |-> $past(tick)); // R10
endmodule

// File: tb/dual_compare_unit_test.sv
module dual_compare_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  // {wide, regA, regB, count, expA, expB}
  typedef struct packed {
    logic        wide;
    logic [7:0]  a;
    logic [7:0]  b;
    logic [15:0] cnt;
    logic        expA;
    logic        expB;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 8'h12, 8'h34, 16'h0012, 1'b1, 1'b0},  // R2
    '{1'b0, 8'h12, 8'h34, 16'hFF34, 1'b0, 1'b1},  // R3
    '{1'b0, 8'h55, 8'h55, 16'h0755, 1'b1, 1'b1},  // R3
    '{1'b0, 8'h10, 8'h20, 16'h0030, 1'b0, 1'b0},  // R2
    '{1'b1, 8'h34, 8'h12, 16'h1234, 1'b1, 1'b0},  // R4
    '{1'b1, 8'h34, 8'h12, 16'h0034, 1'b0, 1'b0},  // R5
    '{1'b1, 8'h12, 8'h12, 16'h0012, 1'b0, 1'b0},  // R4
    '{1'b1, 8'hFF, 8'hFF, 16'hFFFF, 1'b1, 1'b0}   // R4
  };

  logic clk = 0, rstN = 0, tick = 0, wideMode = 0;
  logic [15:0] count = 16'hAAAA;
  logic wrEnA = 0, wrEnB = 0;
  logic [7:0] wrData = 0;
  logic ieA = 0, ieB = 0, ackA = 0, ackB = 0, swClrA = 0, swClrB = 0;
  logic flagA, flagB, irqA, irqB;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_compare_unit uut (
    .clk(clk), .rstN(rstN), .tick(tick), .count(count),
    .wideMode(wideMode), .wrEnA(wrEnA), .wrEnB(wrEnB), .wrData(wrData),
    .ieA(ieA), .ieB(ieB), .ackA(ackA), .ackB(ackB),
    .swClrA(swClrA), .swClrB(swClrB),
    .flagA(flagA), .flagB(flagB), .irqA(irqA), .irqB(irqB)
  );

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic writeRegs(input logic [7:0] a, input logic [7:0] b);
    @(negedge clk); wrEnA = 1; wrData = a;
    @(negedge clk); wrEnA = 0; wrEnB = 1; wrData = b;
    @(negedge clk); wrEnB = 0;
  endtask

  task automatic stepTick(input logic [15:0] c);
    @(negedge clk); count = c; tick = 1;
    @(negedge clk); tick = 0;
  endtask

  task automatic clearFlags();
    @(negedge clk); swClrA = 1; swClrB = 1;
    @(negedge clk); swClrA = 0; swClrB = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 flagA", flagA, 0); check("R1 flagB", flagB, 0);
    check("R1 irqA", irqA, 0);   check("R1 irqB", irqB, 0);
    rstN = 1;
    // R1: registers zero -> wide match on count 0
    wideMode = 1;
    stepTick(16'h0000);
    check("R1 regs zero", flagA, 1);
    clearFlags();

    for (int i = 0; i < NVEC; i++) begin
      wideMode = VECS[i].wide;
      writeRegs(VECS[i].a, VECS[i].b);
      stepTick(VECS[i].cnt ^ 16'h0101);
      clearFlags();
      stepTick(VECS[i].cnt);
      check($sformatf("R2-vector%0d flagA", i), flagA, VECS[i].expA);
      check($sformatf("R3-vector%0d flagB", i), flagB, VECS[i].expB);
    end

    // R10: match without tick
    wideMode = 0;
    writeRegs(8'h40, 8'h41);
    stepTick(16'h0000);
    clearFlags();
    @(negedge clk); count = 16'h0040;
    repeat (5) @(negedge clk);
    check("R10 no tick", flagA, 0);
    stepTick(16'h0040);
    check("R10 tick sets", flagA, 1);

    // R6: persistent match sets once
    clearFlags();
    stepTick(16'h0040);
    check("R6 no re-set", flagA, 0);
    stepTick(16'h0001);
    stepTick(16'h0040);
    check("R6 re-arm", flagA, 1);

    // R7: interrupt gating
    ieA = 0; @(negedge clk);
    check("R7 irqA off", irqA, 0);
    ieA = 1; @(negedge clk);
    check("R7 irqA on", irqA, 1);

    // R8: ack clears A
    @(negedge clk); ackA = 1;
    @(negedge clk); ackA = 0;
    check("R8 ackA", flagA, 0);
    check("R7 irqA after clear", irqA, 0);

    // R8: ack clears B
    stepTick(16'h0000);
    stepTick(16'h0041);
    check("R3 flagB set", flagB, 1);
    ieB = 1; @(negedge clk);
    check("R7 irqB on", irqB, 1);
    @(negedge clk); ackB = 1;
    @(negedge clk); ackB = 0;
    check("R8 ackB", flagB, 0);

    // R9: set beats software clear
    stepTick(16'h0000);
    @(negedge clk); count = 16'h0040; tick = 1; swClrA = 1;
    @(negedge clk); tick = 0; swClrA = 0;
    check("R9 set wins", flagA, 1);
    @(negedge clk); swClrA = 1;
    @(negedge clk); swClrA = 0;
    check("R8 swClrA", flagA, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule